// File: doc/BRIEF.md
# Clock-Stop Serial Peripheral Master

This block is a serial peripheral master that moves one word per request. A word of 1 to `DATA_W` bits goes out on a serial data line, most significant bit first. At the same time it collects the same number of bits from the serial input. The serial clock comes from an integer divider on the block clock. The divide value g sets a clock period of g+1 block cycles. For an odd g the high and low phases are equal. For an even g the high phase is one cycle longer.

Between words the serial clock rests high, the active-low select rests high and the data output driver is disabled. A request is made by pulsing `start` with the word, its length and the divide value. The block latches these and drops select. It drives the first bit at once and waits one full serial period before the first falling edge. On each rising edge it samples the input and then moves to the next output bit. One high phase after the final rising edge, it raises select, releases the data line and pulses `done` together with the received word.

Top module: `csspi_master`

## Requirements
- R1: After reset and while no transfer runs, `spi_sclk` is 1, `spi_sel_n` is 1, `spi_dout_en` is 0, `busy` and `done` are 0, `rx_data` keeps its value (0 after reset), and `spi_sclk` does not toggle.
- R2: With g = `clk_div` (a value of 0 is used as 1), every serial clock period lasts g+1 block cycles.
- R3: For an even g the serial clock high phase lasts g/2+1 cycles and the low phase lasts g/2 cycles.
- R4: For an odd g both the high and low phases last (g+1)/2 cycles.
- R5: In the cycle after an accepted `start`, `spi_sel_n` goes to 0 and `spi_dout_en` goes to 1, with bit n-1 of `tx_data` on `spi_dout`. The first falling edge of `spi_sclk` comes g+1 cycles later.
- R6: Bits leave MSB first, bit n-1 down to bit 0, one per serial period. `spi_dout` changes only in the cycle in which `spi_sclk` rises. `spi_din` is sampled at the block clock edge at which `spi_sclk` rises, and exactly n rising edges occur per word.
- R7: After the last rising edge, `spi_sel_n` stays 0 for one high phase. It then returns to 1 in the same cycle that `spi_dout_en` returns to 0, and `spi_sclk` stays 1.
- R8: `done` is high for exactly one cycle, (g+1)*(n+1) cycles after the `start` edge, in the same cycle that `spi_sel_n` rises. From that cycle `rx_data` holds the n received bits in its low bits, with the first received bit at n-1 and zeros above. `rx_data` changes at no other time.
- R9: `word_len` is sampled with `start`. A value of 0 is used as 1 and values above `DATA_W` are used as `DATA_W`. Bits of `tx_data` at n and above are never sent.
- R10: `busy` is 1 from the cycle after an accepted `start` until `done`. A `start` while `busy` is 1 is ignored, together with the `tx_data`, `word_len` and `clk_div` values presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the divider input |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a transfer (accepted only when idle) |
| tx_data | input | DATA_W | Word to send, right aligned |
| word_len | input | $clog2(DATA_W+1) | Number of bits n |
| clk_div | input | DIV_W | Divide value g |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_data | output | DATA_W | Received word, right aligned |
| spi_sclk | output | 1 | Serial clock, rests high |
| spi_sel_n | output | 1 | Slave select, active low |
| spi_dout | output | 1 | Serial data out |
| spi_dout_en | output | 1 | Output enable for the serial data line |
| spi_din | input | 1 | Serial data in |

## Verification
Select, output enable and the first bit are due one block cycle after the `start` edge. The first clock fall is due g+1 cycles after that, and `done` is due (g+1)*(n+1) cycles after the `start` edge. The bench counts cycles from the `start` edge, sampling at the falling block clock edge. It checks each phase width as the distance between observed clock transitions and checks `done`, `rx_data` and the select rise at exactly the computed cycle. It acts as the slave: it captures `spi_dout` as it stood just before each rising edge, and it updates `spi_din` only after observing that edge.

// File: rtl/csspi_pkg.sv
package csspi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } csspi_state_e;

endpackage

// File: rtl/csspi_div_calc.sv
// Turns a raw divide value into period, high-phase and low-phase lengths.
module csspi_div_calc #(
    parameter int DIV_W = 8,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div_raw,
    output logic [CNT_W-1:0] per_len,
    output logic [CNT_W-1:0] hi_len,
    output logic [CNT_W-1:0] lo_len
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] g_eff;

    always_comb begin
        // a zero divide value runs as one
        g_eff   = (div_raw == '0) ? ONE_C : CNT_W'(div_raw);
        per_len = g_eff + ONE_C;
        // high phase gets the extra cycle when g is even
        hi_len  = (g_eff >> 1) + ONE_C;
        lo_len  = per_len - hi_len;
    end

    // R3 R4
    always_comb begin
        phase_sum_chk: assert (hi_len + lo_len == per_len && lo_len != '0);
    end

endmodule

// File: rtl/csspi_shifter.sv
// Transmit and receive shift registers; transmit word is left aligned.
module csspi_shifter #(
    parameter int DATA_W = 16,
    localparam int LEN_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_in,
    input  logic [LEN_W-1:0]  len,
    input  logic              step,
    input  logic              hold_tx,
    input  logic              din,
    output logic              dout,
    output logic [DATA_W-1:0] rx_word
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } sh_regs_t;

    sh_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.tx = tx_in << (FULL_LEN - len);
            r_d.rx = '0;
        end else if (step) begin
            r_d.rx = {r_q.rx[DATA_W-2:0], din};
            if (!hold_tx) begin
                r_d.tx = {r_q.tx[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout    = r_q.tx[DATA_W-1];
    assign rx_word = r_q.rx;

    // R6
    dout_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(dout));

endmodule

// File: rtl/csspi_master.sv
module csspi_master #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    localparam int LEN_W = $clog2(DATA_W + 1),
    localparam int CNT_W = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              spi_sclk,
    output logic              spi_sel_n,
    output logic              spi_dout,
    output logic              spi_dout_en,
    input  logic              spi_din
);
    import csspi_pkg::*;

    localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
    localparam logic [LEN_W-1:0] ONE_L    = LEN_W'(1);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

    typedef struct packed {
        csspi_state_e      st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  hi;
        logic [CNT_W-1:0]  lo;
        logic [LEN_W-1:0]  bits;
        logic [LEN_W-1:0]  len;
        logic              sclk;
        logic              sel_n;
        logic              oe;
        logic              done;
        logic [DATA_W-1:0] rx_out;
    } regs_t;

    localparam regs_t RESET_REGS = '{
        st:     ST_IDLE,
        cnt:    '0,
        hi:     '0,
        lo:     '0,
        bits:   '0,
        len:    '0,
        sclk:   1'b1,
        sel_n:  1'b1,
        oe:     1'b0,
        done:   1'b0,
        rx_out: '0
    };

    regs_t r_d, r_q;

    logic [CNT_W-1:0]  per_len_w, hi_len_w, lo_len_w;
    logic [LEN_W-1:0]  n_eff;
    logic              load_w, step_w, hold_w;
    logic              shift_dout;
    logic [DATA_W-1:0] shift_rx;

    csspi_div_calc #(.DIV_W(DIV_W)) i_div (
        .div_raw (clk_div),
        .per_len (per_len_w),
        .hi_len  (hi_len_w),
        .lo_len  (lo_len_w)
    );

    csspi_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .tx_in   (tx_data),
        .len     (n_eff),
        .step    (step_w),
        .hold_tx (hold_w),
        .din     (spi_din),
        .dout    (shift_dout),
        .rx_word (shift_rx)
    );

    always_comb begin
        if (word_len == '0) begin
            n_eff = ONE_L;
        end else if (word_len > FULL_LEN) begin
            n_eff = FULL_LEN;
        end else begin
            n_eff = word_len;
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load_w   = 1'b0;
        step_w   = 1'b0;
        hold_w   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_LEAD;
                    r_d.cnt   = per_len_w - ONE_C;
                    r_d.hi    = hi_len_w;
                    r_d.lo    = lo_len_w;
                    r_d.len   = n_eff;
                    r_d.bits  = n_eff;
                    r_d.sel_n = 1'b0;
                    r_d.oe    = 1'b1;
                    load_w    = 1'b1;
                end
            end
            ST_LEAD: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_LOW;
                    r_d.cnt  = r_q.lo - ONE_C;
                    r_d.sclk = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - ONE_C;
                end
            end
            ST_LOW: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_HIGH;
                    r_d.cnt  = r_q.hi - ONE_C;
                    r_d.sclk = 1'b1;
                    r_d.bits = r_q.bits - ONE_L;
                    step_w   = 1'b1;
                    hold_w   = (r_q.bits == ONE_L);
                end else begin
                    r_d.cnt = r_q.cnt - ONE_C;
                end
            end
            ST_HIGH: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - ONE_C;
                end else if (r_q.bits == '0) begin
                    r_d.st     = ST_IDLE;
                    r_d.sel_n  = 1'b1;
                    r_d.oe     = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.rx_out = shift_rx;
                end else begin
                    r_d.st   = ST_LOW;
                    r_d.cnt  = r_q.lo - ONE_C;
                    r_d.sclk = 1'b0;
                end
            end
            default: r_d = RESET_REGS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_REGS;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign rx_data     = r_q.rx_out;
    assign spi_sclk    = r_q.sclk;
    assign spi_sel_n   = r_q.sel_n;
    assign spi_dout_en = r_q.oe;
    assign spi_dout    = shift_dout;

    // R1
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sel_n |-> spi_sclk);

    // R5
    fall_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sclk) |-> (!spi_sel_n && spi_dout_en));

    // R7
    release_at_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sel_n) |-> (spi_sclk && !spi_dout_en && done));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_data));

    // R10
    no_reload_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load_w);

    // R10
    len_kept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(r_q.len));

endmodule

// File: tb/test_csspi_master.sv
module test_csspi_master;

    localparam int DATA_W = 16;
    localparam int DIV_W  = 8;

    typedef struct packed {
        logic [15:0] tx;
        logic [4:0]  len;
        logic [7:0]  gdv;
        logic [15:0] slv;
        logic [15:0] rx;
    } vec_t;

    // tx, word_len, clk_div, slave word, expected rx_data
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'hA5C3, 5'd16, 8'd1, 16'h3C5A, 16'h3C5A},
        '{16'hC3B7, 5'd8,  8'd2, 16'hFF6D, 16'h006D},
        '{16'h0013, 5'd5,  8'd3, 16'h0015, 16'h0015},
        '{16'h1234, 5'd16, 8'd4, 16'hBEEF, 16'hBEEF},
        '{16'h0001, 5'd1,  8'd7, 16'h0001, 16'h0001},
        '{16'h0ACE, 5'd12, 8'd6, 16'hF0F0, 16'h00F0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [15:0]       tx_data = '0;
    logic [4:0]        word_len = '0;
    logic [7:0]        clk_div = '0;
    logic              busy, done;
    logic [15:0]       rx_data;
    logic              spi_sclk, spi_sel_n, spi_dout, spi_dout_en;
    logic              spi_din = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit all_done = 1'b0;

    always #5 clk = ~clk;

    csspi_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_csspi_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .tx_data     (tx_data),
        .word_len    (word_len),
        .clk_div     (clk_div),
        .busy        (busy),
        .done        (done),
        .rx_data     (rx_data),
        .spi_sclk    (spi_sclk),
        .spi_sel_n   (spi_sel_n),
        .spi_dout    (spi_dout),
        .spi_dout_en (spi_dout_en),
        .spi_din     (spi_din)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [15:0] tx, input logic [4:0] len,
                            input logic [7:0] gdv, input logic [15:0] slv,
                            input logic [15:0] exp_rx, input bit poke);
        int g, tp, hp, lp, n, c, rises, first_fall, last_fall, last_rise;
        int err_hi, err_lo, err_tx, err_dx, err_sel, done_c;
        bit fin, prev_sclk, prev_dout;
        logic [15:0] rx_seen;
        g  = (gdv == 0) ? 1 : int'(gdv);
        tp = g + 1;
        hp = g / 2 + 1;
        lp = tp - hp;
        n  = (len == 0) ? 1 : ((len > 16) ? 16 : int'(len));
        @(negedge clk);
        tx_data  = tx;
        word_len = len;
        clk_div  = gdv;
        start    = 1'b1;
        spi_din  = slv[n-1];
        @(negedge clk);
        start = 1'b0;
        // R5: select, enable and first bit one cycle after the start edge
        chk(spi_sel_n == 1'b0 && spi_dout_en == 1'b1 && busy == 1'b1, "R5",
            "sel/en/busy after start", {spi_sel_n, spi_dout_en, busy}, 3'b011);
        chk(spi_dout == tx[n-1], "R5", "first bit before clock", spi_dout, tx[n-1]);
        c = 1; rises = 0; first_fall = -1; last_fall = 0; last_rise = 0;
        err_hi = 0; err_lo = 0; err_tx = 0; err_dx = 0; err_sel = 0;
        done_c = -1; fin = 1'b0; rx_seen = '0;
        prev_sclk = spi_sclk;
        prev_dout = spi_dout;
        while (!fin && c <= tp * (n + 1) + 20) begin
            if (prev_sclk && !spi_sclk) begin
                if (first_fall < 0) first_fall = c;
                else if (c - last_rise != hp) err_hi++;
                last_fall = c;
            end
            if (!prev_sclk && spi_sclk) begin
                if (c - last_fall != lp) err_lo++;
                if (rises >= n || prev_dout != tx[n-1-rises]) err_tx++;
                rises++;
                last_rise = c;
                if (rises < n) spi_din = slv[n-1-rises];
            end else if (spi_dout != prev_dout && !done) begin
                err_dx++;
            end
            if (!done && spi_sel_n) err_sel++;
            if (done) begin
                fin = 1'b1;
                done_c = c;
                rx_seen = rx_data;
                // R7
                chk(spi_sel_n && !spi_dout_en && spi_sclk && !busy, "R7",
                    "release at done", {spi_sel_n, spi_dout_en, spi_sclk, busy}, 4'b1010);
                chk(c - last_rise == hp, "R7", "select hold after last rise",
                    c - last_rise, hp);
            end
            // R10: a second request in flight with other values
            if (poke) begin
                start = (c == 5);
                if (c == 5) begin
                    tx_data  = ~tx;
                    word_len = 5'd3;
                    clk_div  = 8'd2;
                end
            end
            prev_sclk = spi_sclk;
            prev_dout = spi_dout;
            @(negedge clk);
            c++;
        end
        start = 1'b0;
        chk(fin, "R8", "done seen", fin, 1);
        chk(done_c == tp * (n + 1) + 1, "R8", "done cycle", done_c, tp * (n + 1) + 1);
        chk(rx_seen == exp_rx, "R8", "received word", rx_seen, exp_rx);
        chk(!done, "R8", "done one cycle", done, 0);
        chk(rx_data == exp_rx, "R8", "rx held", rx_data, exp_rx);
        chk(first_fall - 1 == tp, "R2", "lead to first fall", first_fall - 1, tp);
        if (g % 2 == 0) begin
            chk(err_hi == 0, "R3", "even high width errors", err_hi, 0);
            chk(err_lo == 0, "R3", "even low width errors", err_lo, 0);
        end else begin
            chk(err_hi == 0, "R4", "odd high width errors", err_hi, 0);
            chk(err_lo == 0, "R4", "odd low width errors", err_lo, 0);
        end
        chk(rises == n, "R6", "rising edge count", rises, n);
        chk(err_tx == 0, "R6", "bit order errors", err_tx, 0);
        chk(err_dx == 0, "R6", "dout moved off rising edge", err_dx, 0);
        chk(err_sel == 0, "R5", "select high mid word", err_sel, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int toggles;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(spi_sclk && spi_sel_n && !spi_dout_en && !busy && !done && rx_data == 0,
            "R1", "reset outputs",
            {spi_sclk, spi_sel_n, spi_dout_en, busy, done}, 5'b11000);
        rst_n = 1'b1;
        toggles = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!spi_sclk || !spi_sel_n || spi_dout_en || done) toggles++;
        end
        chk(toggles == 0, "R1", "idle after reset", toggles, 0);

        for (int v = 0; v < NV; v++) begin
            run_xfer(VECS[v].tx, VECS[v].len, VECS[v].gdv, VECS[v].slv,
                     VECS[v].rx, v == 3);
        end

        // R1: clock rests between words, rx held
        toggles = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!spi_sclk || !spi_sel_n || spi_dout_en || busy || rx_data != 16'h00F0)
                toggles++;
        end
        chk(toggles == 0, "R1", "idle between words", toggles, 0);

        // R2 R9: zero divide runs as one, zero length runs as one bit
        run_xfer(16'hFFFE, 5'd0, 8'd0, 16'h0001, 16'h0001, 1'b0);
        // R9: length above width clamps to full width
        run_xfer(16'h8001, 5'd20, 8'd1, 16'h7FFE, 16'h7FFE, 1'b0);
        // R10: second request in flight on an odd divide
        run_xfer(16'h00A6, 5'd8, 8'd5, 16'h0059, 16'h0059, 1'b1);
        // R9: upper tx bits never sent
        run_xfer(16'hFFF0, 5'd4, 8'd3, 16'h000A, 16'h000A, 1'b0);

        all_done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule